// File: doc/BRIEF.md
# Encoder Position Compare Unit

This block watches the live counters of a quadrature encoder (the phase count within one revolution, the revolution count taken from the index pulse, and the speed count) together with the rotation direction bit. It raises a compare event when the counters reach a programmed target. The phase count must always match its target. The revolution count, the speed count and the direction are qualifiers, and each can be switched out of the condition on its own. The direction qualifier demands either forward or reverse rotation.

A compare event sets a sticky flag. Software clears the flag by writing a status word with a one at bit 29, the bit position shared with the other encoder status flags. The flag feeds an interrupt request through an enable, and each new event sends a one-cycle trigger pulse through a second enable. The flag is set only when the compare condition becomes true, so an encoder that rests on the target does not set the flag again after it has been cleared.

Top module: `enc_pos_cmp`

## Requirements
- R1: A compare event needs `ph_cnt_i` equal to `ph_cmp_i`.
- R2: While `z_cmp_dis_i` is 0, a compare event also needs `z_cnt_i` equal to `z_cmp_i`. While it is 1, the revolution count is ignored.
- R3: While `spd_cmp_dis_i` is 0, a compare event also needs `spd_cnt_i` equal to `spd_cmp_i`. While it is 1, the speed count is ignored.
- R4: While `dir_cmp_dis_i` is 0, a compare event also needs `dir_i` equal to `dir_sel_i`, where 0 is forward rotation and 1 is reverse rotation.
- R5: While `dir_cmp_dis_i` is 1, `dir_i` has no effect on the compare condition.
- R6: `cmp_flag_o` rises on the clock edge that ends the first cycle in which the condition is true after a cycle in which it was false. The first cycle after reset counts as following a false cycle. The flag then stays high until it is cleared.
- R7: A condition that stays true does not set the flag again after a clear.
- R8: A cycle with `clr_wr_i`=1 and `clr_data_i[29]`=1 clears the flag on the next edge. The other bits of `clr_data_i` have no effect.
- R9: If a clear and a new compare event fall in the same cycle, the flag stays set.
- R10: `irq_o` equals `cmp_flag_o` AND `irq_en_i`, with no added delay.
- R11: `trig_o` is high for exactly one cycle, in the same cycle in which a compare event sets the flag, and only if `trig_en_i` was 1 in the cycle of the event.
- R12: While `rst_ni` is low, all outputs are 0. Internal reset ends on the second rising clock edge after `rst_ni` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ph_cnt_i | input | PH_W | Live phase count |
| z_cnt_i | input | Z_W | Live revolution count |
| spd_cnt_i | input | SPD_W | Live speed count |
| dir_i | input | 1 | Rotation direction, 0 forward, 1 reverse |
| ph_cmp_i | input | PH_W | Phase target |
| z_cmp_i | input | Z_W | Revolution target |
| spd_cmp_i | input | SPD_W | Speed target |
| z_cmp_dis_i | input | 1 | Drop the revolution term |
| spd_cmp_dis_i | input | 1 | Drop the speed term |
| dir_sel_i | input | 1 | Required direction |
| dir_cmp_dis_i | input | 1 | Drop the direction term |
| clr_wr_i | input | 1 | Status clear write strobe |
| clr_data_i | input | 32 | Status clear data, bit 29 clears this flag |
| irq_en_i | input | 1 | Interrupt enable |
| trig_en_i | input | 1 | Trigger enable |
| cmp_flag_o | output | 1 | Sticky compare flag |
| irq_o | output | 1 | Interrupt request |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
A new compare event and a software clear can land in the same cycle. The bench causes this by writing the clear during the cycle in which the phase count steps onto its target, and it expects the flag to stay high. It also clears while the encoder rests on the target and expects the flag to stay low. During the sweep over every qualifier setting, clears of bit 29, clears of other bits and compare edges overlap, and a cycle-accurate model in the bench judges each cycle.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

  localparam int unsigned STAT_W  = 32;
  localparam int unsigned CMP_BIT = 29;

  typedef enum logic {
    ROT_FWD = 1'b0,
    ROT_REV = 1'b1
  } rot_e;

  typedef struct packed {
    logic z_off;
    logic spd_off;
    logic dir_off;
    rot_e dir_want;
  } qual_cfg_t;

endpackage

// File: rtl/pcmp_rst_sync.sv
module pcmp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/pcmp_field.sv
module pcmp_field #(
  parameter int unsigned W       = 16,
  parameter bit          CAN_OFF = 1'b1
) (
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] target_i,
  input  logic         off_i,
  output logic         ok_o
);

  logic eq;

  assign eq = (live_i == target_i);

  generate
    if (CAN_OFF) begin : g_maskable
      assign ok_o = eq | off_i;
    end else begin : g_fixed
      logic unused_off;
      assign unused_off = off_i;
      assign ok_o = eq;
    end
  endgenerate

endmodule

// File: rtl/pcmp_qual.sv
module pcmp_qual
  import pcmp_pkg::*;
#(
  parameter int unsigned PH_W  = 16,
  parameter int unsigned Z_W   = 16,
  parameter int unsigned SPD_W = 16
) (
  input  logic [PH_W-1:0]  ph_cnt_i,
  input  logic [Z_W-1:0]   z_cnt_i,
  input  logic [SPD_W-1:0] spd_cnt_i,
  input  logic             dir_i,
  input  logic [PH_W-1:0]  ph_cmp_i,
  input  logic [Z_W-1:0]   z_cmp_i,
  input  logic [SPD_W-1:0] spd_cmp_i,
  input  qual_cfg_t        cfg_i,
  output logic             cond_o
);

  localparam int unsigned N_TERM = 4;

  logic [N_TERM-1:0] term_ok;

  pcmp_field #(.W(PH_W), .CAN_OFF(1'b0)) u_ph (
    .live_i  (ph_cnt_i),
    .target_i(ph_cmp_i),
    .off_i   (1'b0),
    .ok_o    (term_ok[0])
  );

  pcmp_field #(.W(Z_W), .CAN_OFF(1'b1)) u_z (
    .live_i  (z_cnt_i),
    .target_i(z_cmp_i),
    .off_i   (cfg_i.z_off),
    .ok_o    (term_ok[1])
  );

  pcmp_field #(.W(SPD_W), .CAN_OFF(1'b1)) u_spd (
    .live_i  (spd_cnt_i),
    .target_i(spd_cmp_i),
    .off_i   (cfg_i.spd_off),
    .ok_o    (term_ok[2])
  );

  pcmp_field #(.W(1), .CAN_OFF(1'b1)) u_dir (
    .live_i  (dir_i),
    .target_i(cfg_i.dir_want),
    .off_i   (cfg_i.dir_off),
    .ok_o    (term_ok[3])
  );

  assign cond_o = &term_ok;

endmodule

// File: rtl/pcmp_event.sv
module pcmp_event
  import pcmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cond_i,
  input  logic              clr_wr_i,
  input  logic [STAT_W-1:0] clr_data_i,
  input  logic              irq_en_i,
  input  logic              trig_en_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic              trig_o
);

  logic cond_q, cond_d;
  logic flag_q, flag_d;
  logic trig_q, trig_d;
  logic rise;
  logic clr_hit;

  assign clr_hit = clr_wr_i & clr_data_i[CMP_BIT];
  assign rise    = cond_i & ~cond_q;

  always_comb begin
    cond_d = cond_i;
    trig_d = rise & trig_en_i;
    flag_d = flag_q;
    if (clr_hit) begin
      flag_d = 1'b0;
    end
    if (rise) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      cond_q <= cond_d;
      flag_q <= flag_d;
      trig_q <= trig_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
  assign trig_o = trig_q;

  // R7
  stay_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_q && cond_i && !flag_q) |=> !flag_q);

  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && clr_hit && !cond_i) |=> !flag_q);

  // R6
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_wr_i) |=> flag_q);

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i && !cond_q && clr_hit) |=> flag_q);

  // R11
  trig_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> flag_q);

  // R11
  trig_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> !trig_q);

endmodule

// File: rtl/enc_pos_cmp.sv
module enc_pos_cmp
  import pcmp_pkg::*;
#(
  parameter int unsigned PH_W  = 16,
  parameter int unsigned Z_W   = 16,
  parameter int unsigned SPD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PH_W-1:0]   ph_cnt_i,
  input  logic [Z_W-1:0]    z_cnt_i,
  input  logic [SPD_W-1:0]  spd_cnt_i,
  input  logic              dir_i,
  input  logic [PH_W-1:0]   ph_cmp_i,
  input  logic [Z_W-1:0]    z_cmp_i,
  input  logic [SPD_W-1:0]  spd_cmp_i,
  input  logic              z_cmp_dis_i,
  input  logic              spd_cmp_dis_i,
  input  logic              dir_sel_i,
  input  logic              dir_cmp_dis_i,
  input  logic              clr_wr_i,
  input  logic [STAT_W-1:0] clr_data_i,
  input  logic              irq_en_i,
  input  logic              trig_en_i,
  output logic              cmp_flag_o,
  output logic              irq_o,
  output logic              trig_o
);

  logic      rst_sync_n;
  logic      cond;
  qual_cfg_t cfg;

  always_comb begin
    cfg.z_off    = z_cmp_dis_i;
    cfg.spd_off  = spd_cmp_dis_i;
    cfg.dir_off  = dir_cmp_dis_i;
    cfg.dir_want = rot_e'(dir_sel_i);
  end

  pcmp_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  pcmp_qual #(.PH_W(PH_W), .Z_W(Z_W), .SPD_W(SPD_W)) u_qual (
    .ph_cnt_i (ph_cnt_i),
    .z_cnt_i  (z_cnt_i),
    .spd_cnt_i(spd_cnt_i),
    .dir_i    (dir_i),
    .ph_cmp_i (ph_cmp_i),
    .z_cmp_i  (z_cmp_i),
    .spd_cmp_i(spd_cmp_i),
    .cfg_i    (cfg),
    .cond_o   (cond)
  );

  pcmp_event u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .cond_i    (cond),
    .clr_wr_i  (clr_wr_i),
    .clr_data_i(clr_data_i),
    .irq_en_i  (irq_en_i),
    .trig_en_i (trig_en_i),
    .flag_o    (cmp_flag_o),
    .irq_o     (irq_o),
    .trig_o    (trig_o)
  );

  // R1
  phase_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(cmp_flag_o) |-> $past(ph_cnt_i == ph_cmp_i));

  // R2
  rev_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(cmp_flag_o) |-> $past(z_cmp_dis_i || (z_cnt_i == z_cmp_i)));

  // R3
  speed_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(cmp_flag_o) |-> $past(spd_cmp_dis_i || (spd_cnt_i == spd_cmp_i)));

  // R4
  dir_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(cmp_flag_o) |-> $past(dir_cmp_dis_i || (dir_i == dir_sel_i)));

  // R12
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_sync_n |-> (!cmp_flag_o && !irq_o && !trig_o));

endmodule

// File: tb/test_enc_pos_cmp.sv
module test_enc_pos_cmp;

  localparam time CLK_P = 10ns;
  localparam int  PW = 3;
  localparam int  ZW = 2;
  localparam int  SW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [PW-1:0] ph, ph_cmp;
  logic [ZW-1:0] z, z_cmp;
  logic [SW-1:0] spd, spd_cmp;
  logic dir, z_dis, s_dis, dir_sel, dir_dis;
  logic clr_wr, irq_en, trig_en;
  logic [31:0] clr_data;
  logic flag, irq, trig;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic m_flag, m_prev, m_trig;

  always #(CLK_P/2) clk = ~clk;

  enc_pos_cmp #(.PH_W(PW), .Z_W(ZW), .SPD_W(SW)) i_enc_pos_cmp (
    .clk_i(clk), .rst_ni(rst_n),
    .ph_cnt_i(ph), .z_cnt_i(z), .spd_cnt_i(spd), .dir_i(dir),
    .ph_cmp_i(ph_cmp), .z_cmp_i(z_cmp), .spd_cmp_i(spd_cmp),
    .z_cmp_dis_i(z_dis), .spd_cmp_dis_i(s_dis),
    .dir_sel_i(dir_sel), .dir_cmp_dis_i(dir_dis),
    .clr_wr_i(clr_wr), .clr_data_i(clr_data),
    .irq_en_i(irq_en), .trig_en_i(trig_en),
    .cmp_flag_o(flag), .irq_o(irq), .trig_o(trig)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic model_cond();
    return (ph == ph_cmp) && (z_dis || z == z_cmp) &&
           (s_dis || spd == spd_cmp) && (dir_dis || dir == dir_sel);
  endfunction

  // one clock with the current inputs, then compare against the model
  task automatic step(string tag);
    logic c, se, ch;
    c  = model_cond();
    se = c & ~m_prev;
    ch = clr_wr & clr_data[29];
    @(posedge clk);
    m_trig = se & trig_en;
    m_flag = se | (m_flag & ~ch);
    m_prev = c;
    @(negedge clk);
    chk({tag, " flag"}, flag, m_flag);
    chk({tag, " trig"}, trig, m_trig);
    chk({tag, " irq R10"}, irq, m_flag & irq_en);
  endtask

  initial begin
    rst_n = 1'b0;
    ph = 3'd0; ph_cmp = 3'd5; z = '0; z_cmp = 2'd2; spd = '0; spd_cmp = 2'd1;
    dir = 1'b0; z_dis = 1'b0; s_dis = 1'b0; dir_sel = 1'b0; dir_dis = 1'b0;
    clr_wr = 1'b0; clr_data = '0; irq_en = 1'b1; trig_en = 1'b1;
    m_flag = 1'b0; m_prev = 1'b0; m_trig = 1'b0;
    // R12: outputs low during reset even with a true condition
    ph = 3'd5; z = 2'd2; spd = 2'd1;
    repeat (3) @(negedge clk);
    chk("R12 flag", flag, 1'b0);
    chk("R12 irq", irq, 1'b0);
    chk("R12 trig", trig, 1'b0);
    ph = 3'd0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 flag after release", flag, 1'b0);

    // sweep every qualifier setting over every counter value
    for (int cfg = 0; cfg < 16; cfg++) begin
      z_dis = cfg[0]; s_dis = cfg[1]; dir_dis = cfg[2]; dir_sel = cfg[3];
      ph_cmp = PW'(cfg) ^ 3'd5;
      for (int v = 0; v < 256; v++) begin
        ph = v[2:0]; z = v[4:3]; spd = v[6:5]; dir = v[7];
        clr_wr = (v % 5 == 0);
        clr_data = (v % 10 == 0) ? 32'h2000_0000 :
                   ((v % 15 == 0) ? 32'hDFFF_FFFF : 32'h1000_0000);
        irq_en = v[3];
        trig_en = v[4] ^ v[0];
        step("sweep R1/R2/R3/R4/R5/R6/R8/R9/R11");
      end
    end

    // R7: resting on the target after a clear
    clr_wr = 1'b0; trig_en = 1'b1; irq_en = 1'b1;
    z_dis = 1'b1; s_dis = 1'b1; dir_dis = 1'b1; ph_cmp = 3'd4; ph = 3'd1;
    step("R7 idle");
    ph = 3'd4;
    step("R7 hit");
    chk("R7 set", flag, 1'b1);
    clr_wr = 1'b1; clr_data = 32'h2000_0000;
    step("R7 clear");
    chk("R7 cleared", flag, 1'b0);
    clr_wr = 1'b0;
    step("R7 rest");
    step("R7 rest");
    chk("R7 no reset", flag, 1'b0);

    // R8: other bits do not clear
    ph = 3'd0; step("R8 leave");
    ph = 3'd4; step("R8 hit");
    clr_wr = 1'b1; clr_data = 32'hDFFF_FFFF;
    step("R8 other bits");
    chk("R8 kept", flag, 1'b1);
    clr_wr = 1'b0; clr_data = 32'h2000_0000;
    step("R8 data without strobe");
    chk("R8 strobe needed", flag, 1'b1);

    // R9: clear in the cycle of a new edge
    clr_wr = 1'b1; ph = 3'd0;
    step("R9 clear off target");
    chk("R9 cleared", flag, 1'b0);
    ph = 3'd4;
    step("R9 clear with edge");
    chk("R9 set wins", flag, 1'b1);
    chk("R11 pulse", trig, 1'b1);
    clr_wr = 1'b0;
    step("R11 after");
    chk("R11 single", trig, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule